// File: doc/BRIEF.md
# Remote Terminal Data Transfer Sequencer

This block moves data words between a serial-bus remote terminal and a shared memory once a receive or transmit command has been accepted. The word decoder gives it the decoded command fields and a stream of data words, each with a one-cycle valid strobe. The word encoder is driven with a one-cycle start strobe and a 16-bit word, and reports back a busy flag. Every memory access uses an active-low request that is held until an active-low grant arrives. A write or a read completes on the clock edge where both are low.

On a receive command the block stores each arriving word. It then sends the terminal's status word and finally records a transfer status word for the message. On a transmit command the order is different. The status word goes out first. Then each data word is fetched from memory and handed to the encoder, and the transfer status word is written last. When the receive is the second half of a terminal-to-terminal transfer, a timer starts when the command is accepted. If no data word arrives before the timer expires, the message is closed with a word-count error. A data word that arrives while the previous write is still waiting for its grant is not stored, and it sets an overrun flag.

Top module: `rt_xfer_seq`

## Requirements
- R1: After reset the memory request `mem_req_n` is high and `enc_start` is low.
- R2: In a receive, each stored word is written with `mem_wr`=1 and `mem_op_tsw`=0 at address {1'b0, subaddress[4:0], index[4:0]}, where the index counts stored words from 0. The request stays low until the grant and is released on the grant edge.
- R3: A word-count field of 0 means 32 words. Any other value n means n words.
- R4: In a receive, the status word from `status_word` is sent to the encoder only after the last data write has been granted. The transfer status word is written after that.
- R5: In a transmit, the status word is sent first. Then, for each word, a read (`mem_wr`=0) is made at {1'b1, subaddress, index} and the word returned in `mem_rdata` is sent to the encoder. After the last word, the transfer status word is written.
- R6: `enc_start` is a one-cycle pulse. It is raised only when `enc_busy` was low on the previous edge. The encoder must raise `enc_busy` on the edge that samples `enc_start`.
- R7: In a terminal-to-terminal receive (`cmd_rt2rt`=1, `cmd_tx`=0), if no data word arrives within `TMO_CYCLES` clocks of the command, no status word is sent. The transfer status word is written with only the word-count-error bit set (16'h4000).
- R8: A data word that arrives while a write request is still low is dropped. The overrun bit is set, and the store index does not advance.
- R9: The transfer status word is written with `mem_op_tsw`=1 at {cmd_tx, subaddress, 5'b00000}. Its layout is: bit 15 = complete (words moved equals the commanded count), bit 14 = word-count error, bit 13 = overrun, bits 5:0 = words moved, all other bits 0.
- R10: Data words that arrive while no message is active cause no memory access and no encoder start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: accepted command fields are valid |
| cmd_tx | input | 1 | 1 = transmit command, 0 = receive command |
| cmd_rt2rt | input | 1 | Receive is the second half of a terminal-to-terminal transfer |
| cmd_sa | input | 5 | Command subaddress |
| cmd_wc | input | 5 | Command word-count field (0 means 32) |
| rx_valid | input | 1 | One-cycle strobe: decoded data word valid |
| rx_data | input | 16 | Decoded data word |
| status_word | input | 16 | Terminal status word to transmit |
| enc_start | output | 1 | One-cycle start strobe to the encoder |
| enc_data | output | 16 | Word for the encoder |
| enc_busy | input | 1 | Encoder is sending a word |
| mem_req_n | output | 1 | Active-low memory request |
| mem_gnt_n | input | 1 | Active-low memory grant |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_op_tsw | output | 1 | Access is the transfer status word write |
| mem_addr | output | 11 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, sampled on the grant edge |

## Verification
Receives are run with 3 words and with the 0 (32-word) field. These runs separate correct indexing and count decoding from an off-by-one at the 32-word wrap. A transmit with preloaded memory checks the reversed status/data order and shows that the encoded words come from the granted reads. A terminal-to-terminal receive that gets no data is run against one whose data comes early, which separates the timeout from normal completion. A slow grant combined with closely spaced words exposes the overrun path, and data words sent while no message is active must produce no bus activity.

// File: rtl/rt_xfer_seq.sv
module rt_xfer_seq #(
  parameter int TMO_CYCLES = 700
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_tx,
  input  logic        cmd_rt2rt,
  input  logic [4:0]  cmd_sa,
  input  logic [4:0]  cmd_wc,
  input  logic        rx_valid,
  input  logic [15:0] rx_data,
  input  logic [15:0] status_word,
  output logic        enc_start,
  output logic [15:0] enc_data,
  input  logic        enc_busy,
  output logic        mem_req_n,
  input  logic        mem_gnt_n,
  output logic        mem_wr,
  output logic        mem_op_tsw,
  output logic [10:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata
);

  localparam int TW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_STAT, S_TX_STAT, S_TX_REQ, S_TX_SEND, S_TSW
  } st_t;

  st_t         st;
  logic        tx, rt2rt, f_wce, f_ovr;
  logic [4:0]  sa;
  logic [5:0]  need, rcv, idx;
  logic [TW-1:0] tmo;
  logic [15:0] hold;

  wire        granted  = !mem_req_n && !mem_gnt_n;
  wire [5:0]  wc_words = (cmd_wc == 5'd0) ? 6'd32 : {1'b0, cmd_wc};
  wire [15:0] tsw      = {idx == need, f_wce, f_ovr, 7'd0, idx};
  wire        tmo_hit  = tmo == TW'(TMO_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tx         <= 1'b0;
      rt2rt      <= 1'b0;
      f_wce      <= 1'b0;
      f_ovr      <= 1'b0;
      sa         <= '0;
      need       <= '0;
      rcv        <= '0;
      idx        <= '0;
      tmo        <= '0;
      hold       <= '0;
      enc_start  <= 1'b0;
      enc_data   <= '0;
      mem_req_n  <= 1'b1;
      mem_wr     <= 1'b0;
      mem_op_tsw <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      enc_start <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          tx    <= cmd_tx;
          sa    <= cmd_sa;
          rt2rt <= cmd_rt2rt && !cmd_tx;
          need  <= wc_words;
          rcv   <= '0;
          idx   <= '0;
          tmo   <= '0;
          f_wce <= 1'b0;
          f_ovr <= 1'b0;
          st    <= cmd_tx ? S_TX_STAT : S_RX;
        end
        S_RX: begin
          if (granted) begin
            mem_req_n <= 1'b1;
            idx       <= idx + 6'd1;
          end
          if (rx_valid && rcv != need) begin
            rcv <= rcv + 6'd1;
            if (!mem_req_n) f_ovr <= 1'b1;
            else begin
              mem_req_n  <= 1'b0;
              mem_wr     <= 1'b1;
              mem_op_tsw <= 1'b0;
              mem_addr   <= {1'b0, sa, idx[4:0]};
              mem_wdata  <= rx_data;
            end
          end
          if (rt2rt && rcv == 6'd0 && !rx_valid) begin
            if (tmo_hit) begin
              f_wce <= 1'b1;
              st    <= S_TSW;
            end else tmo <= tmo + 1'b1;
          end else if (rcv == need && mem_req_n) st <= S_RX_STAT;
        end
        S_RX_STAT: if (!enc_busy) begin
          enc_start <= 1'b1;
          enc_data  <= status_word;
          st        <= S_TSW;
        end
        S_TX_STAT: if (!enc_busy) begin
          enc_start  <= 1'b1;
          enc_data   <= status_word;
          mem_req_n  <= 1'b0;
          mem_wr     <= 1'b0;
          mem_op_tsw <= 1'b0;
          mem_addr   <= {1'b1, sa, idx[4:0]};
          st         <= S_TX_REQ;
        end
        S_TX_REQ: if (granted) begin
          hold      <= mem_rdata;
          mem_req_n <= 1'b1;
          idx       <= idx + 6'd1;
          st        <= S_TX_SEND;
        end
        S_TX_SEND: if (!enc_busy && !enc_start) begin
          enc_start <= 1'b1;
          enc_data  <= hold;
          if (idx == need) st <= S_TSW;
          else begin
            mem_req_n  <= 1'b0;
            mem_wr     <= 1'b0;
            mem_op_tsw <= 1'b0;
            mem_addr   <= {1'b1, sa, idx[4:0]};
            st         <= S_TX_REQ;
          end
        end
        S_TSW: begin
          if (mem_req_n) begin
            mem_req_n  <= 1'b0;
            mem_wr     <= 1'b1;
            mem_op_tsw <= 1'b1;
            mem_addr   <= {tx, sa, 5'd0};
            mem_wdata  <= tsw;
          end else if (!mem_gnt_n) begin
            mem_req_n <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rt_xfer_seq_chk.sv
module rt_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_n,
  input logic        mem_gnt_n,
  input logic        mem_wr,
  input logic        mem_op_tsw,
  input logic [10:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        enc_start,
  input logic        enc_busy
);

  // R2: request held until grant, with stable address and data
  a_r2_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_gnt_n) |=> !mem_req_n);

  a_r2_stable_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_gnt_n) |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wr)));

  // R2: released on the grant edge
  a_r2_release_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && !mem_gnt_n) |=> mem_req_n);

  // R6: start is a single-cycle pulse issued only after a non-busy cycle
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start |=> !enc_start);

  a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_start) |-> !$past(enc_busy));

  // R9: the status-word operation is always a write
  a_r9_tsw_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_op_tsw) |-> mem_wr);

endmodule

bind rt_xfer_seq rt_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_n(mem_req_n), .mem_gnt_n(mem_gnt_n),
  .mem_wr(mem_wr), .mem_op_tsw(mem_op_tsw), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .enc_start(enc_start), .enc_busy(enc_busy)
);

// File: tb/rt_xfer_seq_tb.sv
module rt_xfer_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_tx = 0, cmd_rt2rt = 0;
  logic [4:0]  cmd_sa = 0, cmd_wc = 0;
  logic        rx_valid = 0;
  logic [15:0] rx_data = 0;
  logic [15:0] status_word = 16'h2800;
  logic        enc_start, enc_busy;
  logic [15:0] enc_data;
  logic        mem_req_n, mem_gnt_n, mem_wr, mem_op_tsw;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  rt_xfer_seq u_dut (.*);

  int n_tests = 0, n_fail = 0, n_events = 0, cyc = 0, gnt_dly = 0;
  logic [28:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] mem [2048];
  int enc_cnt = 0, gcnt = 0;
  assign enc_busy  = enc_cnt != 0;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (enc_start) enc_cnt <= 20;
    else if (enc_cnt != 0) enc_cnt <= enc_cnt - 1;
    if (!mem_req_n && !mem_gnt_n && mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mem_gnt_n <= 1; gcnt <= 0; end
    else if (!mem_req_n && mem_gnt_n) begin
      if (gcnt >= gnt_dly) begin mem_gnt_n <= 0; gcnt <= 0; end
      else gcnt <= gcnt + 1;
    end else begin mem_gnt_n <= 1; gcnt <= 0; end
  end

  task automatic check(input string tag, input logic [28:0] got, input logic [28:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: kind 0 data write, 1 read, 2 status-record write, 3 encoder word
  task automatic observe(input logic [28:0] got);
    n_events++;
    if (exp_q.size() == 0) begin
      n_tests++; n_fail++;
      $display("FAIL R10: unexpected event %h expected none", got);
    end else check(tag_q.pop_front(), got, exp_q.pop_front());
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !mem_req_n && !mem_gnt_n)
      observe({mem_op_tsw ? 2'd2 : (mem_wr ? 2'd0 : 2'd1), mem_addr, mem_wr ? mem_wdata : 16'h0});
    if (rst_n && enc_start) observe({2'd3, 11'd0, enc_data});
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic expect_ev(input logic [1:0] k, input logic [10:0] a, input logic [15:0] d, input string tag);
    exp_q.push_back({k, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic send_cmd(input logic tx, input logic [4:0] sa, input logic [4:0] wc, input logic r2r);
    @(negedge clk);
    cmd_valid = 1; cmd_tx = tx; cmd_sa = sa; cmd_wc = wc; cmd_rt2rt = r2r;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send_word(input logic [15:0] d, input int gap);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (exp_q.size() != 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (30) @(negedge clk);
    check(tag, 29'(exp_q.size()), 29'd0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 req_n", {28'd0, mem_req_n}, 29'd1);
    check("R1 enc_start", {28'd0, enc_start}, 29'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R10: idle words ignored
    begin
      int ev0 = n_events;
      send_word(16'h1111, 5);
      send_word(16'h2222, 20);
      check("R10 no events", 29'(n_events - ev0), 29'd0);
      check("R10 req idle", {28'd0, mem_req_n}, 29'd1);
    end

    // R2 R4 R9: receive of 3 words
    for (int i = 0; i < 3; i++) expect_ev(0, {1'b0, 5'd3, 5'(i)}, 16'hA000 + 16'(i), "R2 rx write");
    expect_ev(3, 0, 16'h2800, "R4 status after data");
    expect_ev(2, {1'b0, 5'd3, 5'd0}, 16'h8003, "R9 tsw rx");
    send_cmd(0, 3, 3, 0);
    for (int i = 0; i < 3; i++) send_word(16'hA000 + 16'(i), 25);
    drain("R4 rx drained");

    // R3: count field 0 gives 32 words
    for (int i = 0; i < 32; i++) expect_ev(0, {1'b0, 5'd31, 5'(i)}, 16'h5500 ^ 16'(i), "R3 rx32 write");
    expect_ev(3, 0, 16'h2800, "R3 status");
    expect_ev(2, {1'b0, 5'd31, 5'd0}, 16'h8020, "R3 tsw count 32");
    send_cmd(0, 31, 0, 0);
    for (int i = 0; i < 32; i++) send_word(16'h5500 ^ 16'(i), 12);
    drain("R3 drained");

    // R5 R9: transmit of 2 words
    mem[{1'b1, 5'd5, 5'd0}] = 16'hBEEF;
    mem[{1'b1, 5'd5, 5'd1}] = 16'hCAFE;
    expect_ev(3, 0, 16'h2800, "R5 status first");
    expect_ev(1, {1'b1, 5'd5, 5'd0}, 0, "R5 read 0");
    expect_ev(3, 0, 16'hBEEF, "R5 send 0");
    expect_ev(1, {1'b1, 5'd5, 5'd1}, 0, "R5 read 1");
    expect_ev(3, 0, 16'hCAFE, "R5 send 1");
    expect_ev(2, {1'b1, 5'd5, 5'd0}, 16'h8002, "R9 tsw tx");
    send_cmd(1, 5, 2, 0);
    drain("R5 drained");

    // R6: transmit with slow grant, encoder pacing
    gnt_dly = 4;
    mem[{1'b1, 5'd12, 5'd0}] = 16'h0F0F;
    expect_ev(3, 0, 16'h2800, "R6 status");
    expect_ev(1, {1'b1, 5'd12, 5'd0}, 0, "R6 read");
    expect_ev(3, 0, 16'h0F0F, "R6 send");
    expect_ev(2, {1'b1, 5'd12, 5'd0}, 16'h8001, "R6 tsw");
    send_cmd(1, 12, 1, 0);
    drain("R6 drained");
    gnt_dly = 0;

    // R7: terminal-to-terminal timeout
    expect_ev(2, {1'b0, 5'd7, 5'd0}, 16'h4000, "R7 timeout tsw");
    send_cmd(0, 7, 2, 1);
    repeat (900) @(negedge clk);
    drain("R7 drained");

    // R7: data arrives in time, normal completion
    expect_ev(0, {1'b0, 5'd8, 5'd0}, 16'h7777, "R7 ontime write");
    expect_ev(3, 0, 16'h2800, "R7 ontime status");
    expect_ev(2, {1'b0, 5'd8, 5'd0}, 16'h8001, "R7 ontime tsw");
    send_cmd(0, 8, 1, 1);
    repeat (50) @(negedge clk);
    send_word(16'h7777, 5);
    drain("R7 ontime drained");

    // R8: overrun while a write waits for grant
    gnt_dly = 10;
    expect_ev(0, {1'b0, 5'd9, 5'd0}, 16'h1234, "R8 first stored");
    expect_ev(0, {1'b0, 5'd9, 5'd1}, 16'h9ABC, "R8 index not advanced");
    expect_ev(3, 0, 16'h2800, "R8 status");
    expect_ev(2, {1'b0, 5'd9, 5'd0}, 16'h2002, "R8 tsw overrun");
    send_cmd(0, 9, 3, 0);
    send_word(16'h1234, 2);
    send_word(16'h5678, 40);
    send_word(16'h9ABC, 5);
    drain("R8 drained");
    gnt_dly = 0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule